// File: doc/BRIEF.md
# Mode-0 Parallel Port with Buffer Gating

This block is a 24-line programmable parallel I/O port that runs only in basic mode 0. A host reaches it over a small register bus: a 2-bit address, an 8-bit write path with a write strobe, and an 8-bit read path qualified by a read strobe. On the pin side there are four groups: an 8-bit group A, an 8-bit group B, and group C split into a high nibble and a low nibble. Each group has its own input, output and output-enable vectors.

A single control word sets the direction of all four groups. Bit 7 of every control write is also captured in a buffer-disable latch that drives a buffer-enable output for the external transceivers. As a result, programming the directions leaves the buffers in tristate. A later control write with bit 7 low turns them back on. A jumper input can hold the buffers on permanently. Output data sits in per-group latches. Input data is not latched: it reaches the read bus straight from the pins.

Top module: `pio24_port`

## Requirements
- R1: After reset every group is an input, all output latches hold zero, all output-enable bits are low and `buf_en` is high.
- R2: A write to address 3 with bit 7 high sets the group directions on the next clock edge. Bit 4 controls A, bit 1 controls B, bit 3 controls the C high nibble and bit 0 controls the C low nibble. A 1 makes the group an input and a 0 makes it an output.
- R3: A write to address 3 with bit 7 high sets the buffer-disable latch. From the next edge `buf_en` is low and every output-enable bit is low, unless `force_en` is high.
- R4: A write to address 3 with bit 7 low clears the buffer-disable latch. It leaves the directions and every output latch, including group C's, unchanged.
- R5: While `force_en` is high, `buf_en` is high whatever the latch holds.
- R6: Every bit of a group's output-enable vector is high exactly when that group is an output and `buf_en` is high.
- R7: Writes to address 0, 1 and 2 load the latch of A, B and C respectively (C bits 7:4 go to the high nibble). The latch appears on the group's output vector after the next clock edge, whatever the direction.
- R8: Reading a group that is an input returns its live pins in the same cycle, with no latching.
- R9: Reading a group that is an output returns its output latch. Address 3 reads as zero, and `bus_rdata` is zero while `bus_re` is low.
- R10: A write to address 3 with bit 7 high clears every output latch to zero.
- R11: Control bits 2, 5 and 6 have no effect: 0xE4 produces the same directions and buffer state as 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| force_en | input | 1 | Jumper: hold buffers enabled |
| buf_en | output | 1 | External buffer enable |
| pa_in | input | 8 | Group A pins in |
| pa_out | output | 8 | Group A output latch |
| pa_oe | output | 8 | Group A output enable |
| pb_in | input | 8 | Group B pins in |
| pb_out | output | 8 | Group B output latch |
| pb_oe | output | 8 | Group B output enable |
| pch_in | input | 4 | Group C high nibble pins in |
| pch_out | output | 4 | Group C high nibble latch |
| pch_oe | output | 4 | Group C high nibble output enable |
| pcl_in | input | 4 | Group C low nibble pins in |
| pcl_out | output | 4 | Group C low nibble latch |
| pcl_oe | output | 4 | Group C low nibble output enable |

## Verification
Register results are due one clock edge after the write strobe: directions, the disable latch, and latch loads or clears. Read data and `buf_en` under the jumper are combinational and are due in the cycle the address, strobe or pins change. The driver applies each stimulus at a falling edge. It queues its expectations only after the rising edge that commits a write, and it holds the bus steady while the monitor compares one falling edge later. Both kinds of result are therefore sampled when they are settled.

// File: rtl/pio24_pkg.sv
// Shared constants and types for the mode-0 parallel port.
// Assumes a fixed four-group layout (A, B, C high, C low).
package pio24_pkg;
    localparam int BUS_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int WIDE_W  = 8;
    localparam int NIB_W   = 4;

    localparam logic [ADDR_W-1:0] SEL_A    = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_B    = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_C    = 2'd2;
    localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd3;

    // control word bit positions decoded by the host driver
    localparam int CB_CLO = 0;
    localparam int CB_B   = 1;
    localparam int CB_CHI = 3;
    localparam int CB_A   = 4;
    localparam int CB_SET = 7;

    // one flag per group, 1 = input
    typedef struct packed {
        logic a;
        logic b;
        logic chi;
        logic clo;
    } dir_t;

    localparam dir_t DIR_ALL_IN = '{a: 1'b1, b: 1'b1, chi: 1'b1, clo: 1'b1};
endpackage

// File: rtl/pio24_ctrl.sv
// Control register and buffer gating.
// Holds the group directions and the buffer-disable latch, both loaded by
// writes to the control address. Bit 7 high loads directions and sets the
// latch; bit 7 low only clears the latch. Mode bits are ignored.
// Assumes wr_en is a single-cycle qualified control write.
module pio24_ctrl
    import pio24_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    input  logic             force_en,
    output dir_t             dir,
    output logic             set_pulse,
    output logic             buf_en
);
    dir_t dir_q;
    logic dis_q;

    // Purpose: a control write with the set flag is a full reprogram
    assign set_pulse = wr_en & wdata[CB_SET];

    // Purpose: direction register, loaded only by a set-flag control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_ALL_IN;
        end else if (set_pulse) begin
            dir_q.a   <= wdata[CB_A];
            dir_q.b   <= wdata[CB_B];
            dir_q.chi <= wdata[CB_CHI];
            dir_q.clo <= wdata[CB_CLO];
        end
    end

    // Purpose: buffer-disable latch follows bit 7 of every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b0;
        end else if (wr_en) begin
            dis_q <= wdata[CB_SET];
        end
    end

    // Purpose: jumper overrides the latch
    always_comb begin
        buf_en = force_en | ~dis_q;
    end

    assign dir = dir_q;
endmodule

// File: rtl/pio24_group.sv
// One port group of parameterised width.
// Holds the output latch, gates the output enable by direction and buffer
// enable, and selects read data: live pins when input, latch when output.
// Assumes clr and wr_en are never high in the same cycle.
module pio24_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         clr,
    input  logic         is_in,
    input  logic         buf_en,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] lat_q;

    // Purpose: output latch, cleared by reprogramming, loaded by port writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (clr) begin
            lat_q <= '0;
        end else if (wr_en) begin
            lat_q <= wr_data;
        end
    end

    // Purpose: drive enable only for an output group with buffers on
    always_comb begin
        pin_oe = {W{~is_in & buf_en}};
    end

    // Purpose: unlatched pins for inputs, latch for outputs
    always_comb begin
        rd_val = is_in ? pin_in : lat_q;
    end

    assign pin_out = lat_q;
endmodule

// File: rtl/pio24_port.sv
// Top of the mode-0 parallel port.
// Decodes the host bus, instantiates the control block and the four groups,
// and assembles read data. Assumes one access per cycle, with reads combinational.
module pio24_port
    import pio24_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              force_en,
    output logic              buf_en,
    input  logic [WIDE_W-1:0] pa_in,
    output logic [WIDE_W-1:0] pa_out,
    output logic [WIDE_W-1:0] pa_oe,
    input  logic [WIDE_W-1:0] pb_in,
    output logic [WIDE_W-1:0] pb_out,
    output logic [WIDE_W-1:0] pb_oe,
    input  logic [NIB_W-1:0]  pch_in,
    output logic [NIB_W-1:0]  pch_out,
    output logic [NIB_W-1:0]  pch_oe,
    input  logic [NIB_W-1:0]  pcl_in,
    output logic [NIB_W-1:0]  pcl_out,
    output logic [NIB_W-1:0]  pcl_oe
);
    dir_t              dir;
    logic              set_pulse;
    logic              ctl_wr, wr_a, wr_b, wr_c;
    logic [WIDE_W-1:0] rd_a, rd_b;
    logic [NIB_W-1:0]  rd_ch, rd_cl;

    // Purpose: address decode of write strobes
    always_comb begin
        ctl_wr = bus_we && (bus_addr == SEL_CTRL);
        wr_a   = bus_we && (bus_addr == SEL_A);
        wr_b   = bus_we && (bus_addr == SEL_B);
        wr_c   = bus_we && (bus_addr == SEL_C);
    end

    pio24_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_wr),
        .wdata     (bus_wdata),
        .force_en  (force_en),
        .dir       (dir),
        .set_pulse (set_pulse),
        .buf_en    (buf_en)
    );

    pio24_group #(.W(WIDE_W)) u_grp_a (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_a), .wr_data (bus_wdata),
        .clr (set_pulse), .is_in (dir.a), .buf_en (buf_en),
        .pin_in (pa_in), .pin_out (pa_out), .pin_oe (pa_oe), .rd_val (rd_a)
    );

    pio24_group #(.W(WIDE_W)) u_grp_b (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_b), .wr_data (bus_wdata),
        .clr (set_pulse), .is_in (dir.b), .buf_en (buf_en),
        .pin_in (pb_in), .pin_out (pb_out), .pin_oe (pb_oe), .rd_val (rd_b)
    );

    pio24_group #(.W(NIB_W)) u_grp_ch (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_c),
        .wr_data (bus_wdata[BUS_W-1:NIB_W]),
        .clr (set_pulse), .is_in (dir.chi), .buf_en (buf_en),
        .pin_in (pch_in), .pin_out (pch_out), .pin_oe (pch_oe), .rd_val (rd_ch)
    );

    pio24_group #(.W(NIB_W)) u_grp_cl (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_c),
        .wr_data (bus_wdata[NIB_W-1:0]),
        .clr (set_pulse), .is_in (dir.clo), .buf_en (buf_en),
        .pin_in (pcl_in), .pin_out (pcl_out), .pin_oe (pcl_oe), .rd_val (rd_cl)
    );

    // Purpose: read mux; control address and idle strobe read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (bus_addr)
                SEL_A:   bus_rdata = rd_a;
                SEL_B:   bus_rdata = rd_b;
                SEL_C:   bus_rdata = {rd_ch, rd_cl};
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio24_port_chk.sv
// Protocol checker for pio24_port, bound to every instance.
// Observes only top-level ports.
module pio24_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_we,
    input logic       bus_re,
    input logic [7:0] bus_rdata,
    input logic       force_en,
    input logic       buf_en,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [3:0] pch_out,
    input logic [3:0] pch_oe,
    input logic [3:0] pcl_out,
    input logic [3:0] pcl_oe
);
    // R5
    jumper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_en |-> buf_en);

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_oe | pb_oe) != 8'd0 || (pch_oe | pcl_oe) != 4'd0) |-> buf_en);

    // R3
    set_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3 && bus_wdata[7]) |=> (force_en || (!buf_en && pa_oe == 8'd0)));

    // R4
    clear_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3 && !bus_wdata[7]) |=> buf_en);

    // R10
    set_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3 && bus_wdata[7]) |=>
        (pa_out == 8'd0 && pb_out == 8'd0 && pch_out == 4'd0 && pcl_out == 4'd0));

    // R7
    a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=> (pa_out == $past(bus_wdata)));

    // R9
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_re || bus_addr == 2'd3) |-> (bus_rdata == 8'd0));
endmodule

bind pio24_port pio24_port_chk u_chk (.*);

// File: tb/pio24_port_bench.sv
module pio24_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       force_en = 1'b0;
    logic       buf_en;
    logic [7:0] pa_in = '0, pa_out, pa_oe;
    logic [7:0] pb_in = '0, pb_out, pb_oe;
    logic [3:0] pch_in = '0, pch_out, pch_oe;
    logic [3:0] pcl_in = '0, pcl_out, pcl_oe;

    always #2 clk = ~clk;

    pio24_port u_pio24_port (.*);

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return bus_rdata;
            1: return pa_out;
            2: return pa_oe;
            3: return pb_out;
            4: return pb_oe;
            5: return {pch_out, pcl_out};
            6: return {pch_oe, pcl_oe};
            default: return {7'd0, buf_en};
        endcase
    endfunction

    // monitor: pops queued expectations one falling edge later
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (observe(it.sel) !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h",
                             it.req, it.sel, observe(it.sel), it.exp);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic expect_v(int sel, logic [7:0] e, string req);
        item_t it;
        it.sel = sel; it.exp = e; it.req = req;
        q.push_back(it);
    endtask

    task automatic settle();
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_expect(logic [1:0] a, logic [7:0] e, string req);
        bus_addr = a; bus_re = 1'b1;
        expect_v(0, e, req);
        settle();
        bus_re = 1'b0;
    endtask

    initial begin
        pa_in = 8'h5A; pb_in = 8'h11; pch_in = 4'h7; pcl_in = 4'h2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_v(1, 8'h00, "R1"); expect_v(2, 8'h00, "R1");
        expect_v(4, 8'h00, "R1"); expect_v(6, 8'h00, "R1");
        expect_v(7, 8'h01, "R1");
        settle();
        rd_expect(2'd0, 8'h5A, "R1");
        // R7 latch loads while input; R8 read still live
        wr(2'd0, 8'h3C);
        expect_v(1, 8'h3C, "R7"); expect_v(2, 8'h00, "R6");
        settle();
        rd_expect(2'd0, 8'h5A, "R8");
        wr(2'd2, 8'h0F);
        expect_v(5, 8'h0F, "R7"); settle();
        // R2/R3/R10: all outputs, buffers off, latches cleared
        wr(2'd3, 8'h80);
        expect_v(7, 8'h00, "R3"); expect_v(2, 8'h00, "R3");
        expect_v(1, 8'h00, "R10"); expect_v(5, 8'h00, "R10");
        settle();
        rd_expect(2'd0, 8'h00, "R9");
        wr(2'd0, 8'hA5);
        wr(2'd2, 8'h0E);
        // R4 bit7 low: re-enable, no bit set on C, latches kept
        wr(2'd3, 8'h01);
        expect_v(7, 8'h01, "R4"); expect_v(1, 8'hA5, "R4");
        expect_v(5, 8'h0E, "R4");
        expect_v(2, 8'hFF, "R6"); expect_v(4, 8'hFF, "R6"); expect_v(6, 8'hFF, "R6");
        settle();
        rd_expect(2'd0, 8'hA5, "R9");
        // R2 mixed directions: A, C hi, C lo in; B out
        wr(2'd3, 8'h99);
        wr(2'd3, 8'h00);
        expect_v(2, 8'h00, "R2"); expect_v(4, 8'hFF, "R2"); expect_v(6, 8'h00, "R2");
        settle();
        pa_in = 8'hC3;
        rd_expect(2'd0, 8'hC3, "R8");
        rd_expect(2'd2, 8'h72, "R8");
        // R2 only C low and A in
        wr(2'd3, 8'h91);
        wr(2'd3, 8'h00);
        expect_v(6, 8'hF0, "R2"); expect_v(2, 8'h00, "R2"); settle();
        wr(2'd2, 8'hB6);
        rd_expect(2'd2, 8'hB2, "R9");
        wr(2'd1, 8'h4D);
        rd_expect(2'd1, 8'h4D, "R9");
        // R11 mode bits ignored
        wr(2'd3, 8'hE4);
        expect_v(7, 8'h00, "R11"); settle();
        wr(2'd3, 8'h00);
        expect_v(2, 8'hFF, "R11"); expect_v(4, 8'hFF, "R11");
        expect_v(6, 8'hFF, "R11"); settle();
        // R5 jumper holds buffers on
        force_en = 1'b1;
        wr(2'd3, 8'h80);
        expect_v(7, 8'h01, "R5"); expect_v(2, 8'hFF, "R5"); settle();
        force_en = 1'b0;
        expect_v(7, 8'h00, "R5"); expect_v(6, 8'h00, "R6"); settle();
        // R9 control reads zero, idle strobe zero
        rd_expect(2'd3, 8'h00, "R9");
        bus_addr = 2'd1;
        expect_v(0, 8'h00, "R9"); settle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule